// File: doc/BRIEF.md
# Host-Bus Receive FIFO Burst Read Port

This block is the slave side of an asynchronous host bus through which an external processor drains a receive data FIFO. The host frames each access with two active-low strobes, a chip select and a read enable. The access is live only while both strobes are low, and the strobes may fall and rise in either order. The strobes and a FIFO-select input are synchronised into the core clock. The port notices when an access begins and when it ends, drives the captured word onto the data bus with tri-state enables, and removes one entry from the FIFO when the transfer completes.

With FIFO-select high, the host can stream any number of words with an incrementing address, because the upper address bits are no longer decoded. With FIFO-select low, only one register address reaches the FIFO. A 16-bit bus mode returns one half of the current word per access and consumes the entry after its upper half has been read. The FIFO is a small synchronous queue filled from the core side.

Top module: `hbus_fifo_rd_port`

## Requirements
- R1: An access starts only when `csN` and `rdN` are low together. Holding just one of them low, for any length of time, enables no driver and consumes no FIFO entry.
- R2: An access ends when either strobe rises, or both rise. The strobes may be asserted in either order and released in any combination. The enables drop on the third rising clock edge after the release.
- R3: In 32-bit mode (`busWide`=1), each completed access that selects the FIFO returns the oldest entry on `dataOut` and removes exactly that one entry, so successive accesses return entries in the order they were pushed.
- R4: With `fifoSel`=1, every value of `busAddr[6:1]` (A[7:2]) selects the FIFO. With `fifoSel`=0, only `busAddr[6:1]` == `FIFO_REG` selects it. Any other address leaves both enables low and consumes nothing.
- R5: A burst may be paced by toggling either strobe while the other one stays low. Every pulse is a full access, with no limit on burst length.
- R6: In 16-bit mode (`busWide`=0), `dataOeHi` stays low and `dataOut[31:16]` reads zero. `busAddr[0]` (A[1]) picks the lower half (0) or the upper half (1) of the oldest entry. Only an access with `busAddr[0]`=1 removes the entry.
- R7: An access that selects an empty FIFO returns all zeros, removes nothing and sets `underrun`. `underrun` stays set until reset, and later data comes back intact.
- R8: `dataOeLo` rises on the third rising clock edge after both strobes are low, and never earlier. Both enables are low in reset and whenever no access is active.
- R9: `fifoFull` is high exactly when `DEPTH` entries are held. A push while the FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Core-side write of one FIFO entry |
| pushData | input | DATA_W | Entry written by the core |
| fifoFull | output | 1 | FIFO holds DEPTH entries |
| csN | input | 1 | Host chip select, active low, asynchronous |
| rdN | input | 1 | Host read enable, active low, asynchronous |
| fifoSel | input | 1 | Forces the access to target the FIFO |
| busAddr | input | ADDR_W | Host address A[7:1]; bit 0 is A[1] |
| busWide | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus (static) |
| dataOut | output | DATA_W | Data presented to the bus pads |
| dataOeLo | output | 1 | Drive enable for dataOut[15:0] |
| dataOeHi | output | 1 | Drive enable for dataOut[31:16] |
| underrun | output | 1 | Sticky: an empty FIFO was read |

## Verification
The hardest cases to reach are the split strobe orderings. In these, one strobe stays low across several accesses, so the start or the end of an access is marked by the other strobe alone. The stimulus drives the two strobes independently on falling clock edges and covers every pairing of assertion order with release pattern. It then runs long bursts paced by each strobe in turn while the other is held low. The decode bypass is checked by sweeping all 64 values of A[7:2] with FIFO-select both low and high. A wrong pop shows up as a mismatch on the next data word the bench reads.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic load;       // capture a word into the output register
    logic zeroFill;   // captured value must be all zeros (empty FIFO)
    logic upperHalf;  // narrow bus: present the upper half
    logic pop;        // remove the oldest FIFO entry
  } dpCtrl_t;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta;
    logic stable;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        meta   <= RST_VAL[i];
        stable <= RST_VAL[i];
      end else begin
        meta   <= asyncIn[i];
        stable <= meta;
      end
    end
    assign syncOut[i] = stable;
  end
endmodule

// File: rtl/hbus_fifo.sv
module hbus_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = pushValid && !full;
  assign doPop  = popReq && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushValid && !popReq) |=> full);
endmodule

// File: rtl/hbus_datapath.sv
module hbus_datapath
  import hbus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              busWide,
  input  dpCtrl_t           strobes,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic [DATA_W-1:0] dataOut
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] headWord;
  logic [DATA_W-1:0] nextWord;
  logic [DATA_W-1:0] dataQ;

  hbus_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushValid(pushValid),
    .pushData (pushData),
    .popReq   (strobes.pop),
    .head     (headWord),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  always_comb begin
    if (strobes.zeroFill)
      nextWord = '0;
    else if (busWide)
      nextWord = headWord;
    else if (strobes.upperHalf)
      nextWord = {{HALF_W{1'b0}}, headWord[DATA_W-1:HALF_W]};
    else
      nextWord = {{HALF_W{1'b0}}, headWord[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)             dataQ <= '0;
    else if (strobes.load) dataQ <= nextWord;
  end

  assign dataOut = dataQ;

  assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !busWide) |=> (dataOut[DATA_W-1:HALF_W] == '0));
  assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> !fifoEmpty);
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-2:0] FIFO_REG = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csSync,
  input  logic              rdSync,
  input  logic              selSync,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWide,
  input  logic              fifoEmpty,
  output dpCtrl_t           strobes,
  output logic              busOe,
  output logic              underrun
);
  logic active, activeQ, startEv, endEv, hit;
  logic cycQ, emptyQ, upperQ, wideQ, underQ;

  assign active  = !csSync && !rdSync;
  assign startEv = active && !activeQ;
  assign endEv   = !active && activeQ;
  // FIFO-select drops the register decode of A[7:2]; A[1] keeps its half role.
  assign hit     = selSync || (busAddr[ADDR_W-1:1] == FIFO_REG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      cycQ    <= 1'b0;
      emptyQ  <= 1'b0;
      upperQ  <= 1'b0;
      wideQ   <= 1'b1;
      underQ  <= 1'b0;
    end else begin
      activeQ <= active;
      if (startEv) begin
        cycQ   <= hit;
        emptyQ <= fifoEmpty;
        upperQ <= busAddr[0];
        wideQ  <= busWide;
        if (hit && fifoEmpty) underQ <= 1'b1;
      end else if (endEv) begin
        cycQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.load      = startEv && hit;
    strobes.zeroFill  = fifoEmpty;
    strobes.upperHalf = busAddr[0];
    strobes.pop       = endEv && cycQ && !emptyQ && (wideQ || upperQ);
  end

  assign busOe    = cycQ;
  assign underrun = underQ;

  assert_single_pop_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> !strobes.pop);
  assert_oe_framed_R8: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> $past(!csSync && !rdSync));
  assert_oe_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && (csSync || rdSync)) |=> !busOe);
  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);
endmodule

// File: rtl/hbus_fifo_rd_port.sv
module hbus_fifo_rd_port
  import hbus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-2:0] FIFO_REG = 6'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  output logic              fifoFull,
  input  logic              csN,
  input  logic              rdN,
  input  logic              fifoSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWide,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOeLo,
  output logic              dataOeHi,
  output logic              underrun
);
  logic [2:0] syncBits;
  logic       fifoEmpty, busOe;
  dpCtrl_t    strobes;

  hbus_sync #(.WIDTH(3), .RST_VAL(3'b011)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({fifoSel, rdN, csN}),
    .syncOut(syncBits)
  );

  hbus_ctrl #(.ADDR_W(ADDR_W), .FIFO_REG(FIFO_REG)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csSync   (syncBits[0]),
    .rdSync   (syncBits[1]),
    .selSync  (syncBits[2]),
    .busAddr  (busAddr),
    .busWide  (busWide),
    .fifoEmpty(fifoEmpty),
    .strobes  (strobes),
    .busOe    (busOe),
    .underrun (underrun)
  );

  hbus_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pushValid(pushValid),
    .pushData (pushData),
    .busWide  (busWide),
    .strobes  (strobes),
    .fifoFull (fifoFull),
    .fifoEmpty(fifoEmpty),
    .dataOut  (dataOut)
  );

  assign dataOeLo = busOe;
  assign dataOeHi = busOe && busWide;
endmodule

// File: tb/hbus_fifo_rd_port_bench.sv
module hbus_fifo_rd_port_bench;
  localparam int DEPTH = 8;
  localparam logic [5:0] REG = 6'h2B;

  logic        clk = 1'b0;
  logic        rstN, pushValid, csN, rdN, fifoSel, busWide;
  logic [31:0] pushData;
  logic [6:0]  busAddr;
  logic        fifoFull, dataOeLo, dataOeHi, underrun;
  logic [31:0] dataOut;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] mq [0:1023];
  int mHead = 0, mTail = 0;
  bit expUnder = 0;

  always #2.5 clk = ~clk;

  hbus_fifo_rd_port #(.DATA_W(32), .DEPTH(DEPTH), .ADDR_W(7), .FIFO_REG(REG))
    u_hbus_fifo_rd_port (
      .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
      .fifoFull(fifoFull), .csN(csN), .rdN(rdN), .fifoSel(fifoSel),
      .busAddr(busAddr), .busWide(busWide), .dataOut(dataOut),
      .dataOeLo(dataOeLo), .dataOeHi(dataOeHi), .underrun(underrun));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FIFO-PORT FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 0; pushValid = 0; pushData = 0; csN = 1; rdN = 1;
    fifoSel = 0; busAddr = 0; busWide = 1;
    waitNeg(4);
    rstN = 1;
    mHead = 0; mTail = 0; expUnder = 0;
    waitNeg(1);
  endtask

  task automatic pushWord(input logic [31:0] d);
    pushValid = 1; pushData = d;
    if (mTail - mHead < DEPTH) begin mq[mTail % 1024] = d; mTail++; end
    waitNeg(1);
    pushValid = 0;
    check(fifoFull == (mTail - mHead == DEPTH), "R9 full flag", 32'(fifoFull),
          32'(mTail - mHead == DEPTH));
  endtask

  // order: 0 both, 1 cs then rd, 2 rd then cs, 3 cs only (rd held), 4 rd only (cs held)
  // rel:   0 both, 1 cs only, 2 rd only
  task automatic doCycle(input int order, input int rel, input logic sel,
                         input logic [6:0] a, input string req);
    bit hitE, emptyE;
    logic [31:0] expD, h;
    hitE   = sel || (a[6:1] == REG);
    emptyE = (mTail == mHead);
    h      = emptyE ? 32'h0 : mq[mHead % 1024];
    expD   = busWide ? h : (a[0] ? {16'h0, h[31:16]} : {16'h0, h[15:0]});
    fifoSel = sel; busAddr = a;
    case (order)
      0: begin csN = 0; rdN = 0; end
      1: begin csN = 0; waitNeg(1); rdN = 0; end
      2: begin rdN = 0; waitNeg(1); csN = 0; end
      3: csN = 0;
      default: rdN = 0;
    endcase
    waitNeg(2);
    check(dataOeLo == 0, {req, " R8 no early enable"}, 32'(dataOeLo), 0);
    waitNeg(1);
    check(dataOeLo == hitE, {req, " enable"}, 32'(dataOeLo), 32'(hitE));
    check(dataOeHi == (hitE && busWide), {req, " R6 upper enable"}, 32'(dataOeHi),
          32'(hitE && busWide));
    if (hitE) check(dataOut == expD, {req, " data"}, dataOut, expD);
    waitNeg(1);
    case (rel)
      0: begin csN = 1; rdN = 1; end
      1: csN = 1;
      default: rdN = 1;
    endcase
    waitNeg(2);
    check(dataOeLo == hitE, {req, " R2 enable held"}, 32'(dataOeLo), 32'(hitE));
    waitNeg(1);
    check(dataOeLo == 0, {req, " R2 enable released"}, 32'(dataOeLo), 0);
    if (hitE && emptyE) expUnder = 1;
    if (hitE && !emptyE && (busWide || a[0])) mHead++;
    check(underrun == expUnder, {req, " R7 underrun"}, 32'(underrun), 32'(expUnder));
  endtask

  task automatic idle();
    csN = 1; rdN = 1; waitNeg(4);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FIFO-PORT FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // Reset state (R8, R7, R9)
    check(dataOeLo == 0 && dataOeHi == 0, "R8 reset enables", {dataOeHi, dataOeLo}, 0);
    check(underrun == 0, "R7 reset underrun", 32'(underrun), 0);
    check(fifoFull == 0, "R9 reset full", 32'(fifoFull), 0);
    check(dataOut == 0, "R3 reset data", dataOut, 0);

    // R1: one strobe alone does nothing
    pushWord(32'h1111_0001); pushWord(32'h2222_0002);
    fifoSel = 1; csN = 0;
    for (int i = 0; i < 6; i++) begin
      waitNeg(1); check(dataOeLo == 0, "R1 cs alone", 32'(dataOeLo), 0);
    end
    csN = 1; waitNeg(3); rdN = 0;
    for (int i = 0; i < 6; i++) begin
      waitNeg(1); check(dataOeLo == 0, "R1 rd alone", 32'(dataOeLo), 0);
    end
    rdN = 1; waitNeg(3);
    doCycle(0, 0, 1, 7'h00, "R1 first word intact");
    idle();

    // R2: every assertion order against every release pattern
    for (int o = 0; o < 3; o++)
      for (int r = 0; r < 3; r++) begin
        pushWord(32'hC0DE_0000 + 32'(o * 16 + r));
        doCycle(o, r, 1, 7'(o * 3 + r), "R2 order/release R3");
        idle();
      end

    // R4: full sweep of A[7:2] with fifoSel low, then high
    for (int s = 0; s < 2; s++)
      for (int hi = 0; hi < 64; hi++) begin
        if (mTail - mHead < 2) pushWord(32'hA5A5_0000 ^ 32'(hi * 257 + s));
        doCycle(0, 0, s[0], {hi[5:0], hi[0]}, "R4 decode");
        idle();
      end

    // R5: bursts paced by cs with rd held, then by rd with cs held
    while (mTail != mHead) begin doCycle(0, 0, 1, 7'h00, "R3 drain"); idle(); end
    for (int i = 0; i < DEPTH; i++) pushWord(32'h5000_0000 + 32'(i * 3));
    rdN = 0;
    for (int i = 0; i < DEPTH; i++) doCycle(3, 1, 1, 7'(i), "R5 cs-paced R3");
    idle();
    for (int i = 0; i < DEPTH; i++) pushWord(32'h6000_0000 + 32'(i * 5));
    csN = 0;
    for (int i = 0; i < DEPTH; i++) doCycle(4, 2, 1, 7'(2 * i), "R5 rd-paced R3");
    idle();

    // R6: 16-bit mode, low half twice then high half
    busWide = 0; waitNeg(1);
    for (int i = 0; i < 4; i++) pushWord(32'h8000_0001 * 32'(i + 1) ^ 32'h00FF_FF00);
    for (int i = 0; i < 4; i++) begin
      doCycle(0, 0, 1, 7'h00, "R6 low half"); idle();
      doCycle(0, 0, 1, 7'h00, "R6 low half again"); idle();
      doCycle(0, 0, 1, 7'h01, "R6 high half"); idle();
    end
    busWide = 1; waitNeg(1);

    // R9 overflow drop, then R7 empty read
    for (int i = 0; i < DEPTH + 2; i++) pushWord(32'h9000_0000 + 32'(i));
    for (int i = 0; i < DEPTH; i++) begin doCycle(0, 0, 1, 7'(i), "R9 drain"); idle(); end
    doCycle(0, 0, 1, 7'h00, "R7 empty read"); idle();
    doCycle(2, 1, 1, 7'h10, "R7 empty again"); idle();
    pushWord(32'hBEEF_CAFE);
    doCycle(0, 0, 1, 7'h00, "R7 data after underrun"); idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule